// File: doc/BRIEF.md
# Interrupt Destination Match Logic

This block answers one question for a local interrupt controller: is it a target of an inter-processor message that is being broadcast to every controller? It takes the controller's configuration and the message's addressing fields. The configuration is the ID register, the logical destination register, the destination format register, the legacy or extended addressing mode and the software-enable state. The message fields are the destination word, the physical or logical flag, a two-bit shorthand and a flag that marks this controller as the sender. From these it returns one match bit.

The decision is purely combinational. A registered copy of the match bit is also provided for paths that need a flop boundary before the next stage. The block handles the following cases:
- physical addressing, with broadcast in both modes;
- flat and clustered logical addressing in legacy mode;
- extended-mode logical addressing, where the logical ID is derived from the controller's own ID;
- the four shorthand codes.

Transport, arbitration among targets and delivery semantics belong to other blocks.

Top module: `dest_match_unit`

## Requirements
- R1: In legacy mode with physical addressing and shorthand 0, match is 1 exactly when dest[7:0] equals id_reg[31:24]. dest[31:8] has no effect.
- R2: In legacy mode with physical addressing and shorthand 0, dest[7:0] = 8'hFF matches every controller whatever its ID.
- R3: In extended mode with physical addressing and shorthand 0, match is 1 exactly when the full 32-bit dest equals id_reg or equals 32'hFFFFFFFF.
- R4: Legacy logical addressing uses the flat model when dfr_reg[31:28] = 4'hF. With shorthand 0 and the controller enabled, match is 1 exactly when ldr_reg[31:24] AND dest[7:0] is non-zero.
- R5: Legacy logical addressing uses the cluster model when dfr_reg[31:28] = 4'h0. Match requires ldr_reg[31:28] == dest[7:4] and a non-zero ldr_reg[27:24] AND dest[3:0]. Any other model code gives no logical match, and dfr_reg[27:0] has no effect.
- R6: In extended mode the logical ID is {id_reg[19:4], a 16-bit one-hot with bit id_reg[3:0] set}. A logical message matches when this value AND the 32-bit dest is non-zero. The ldr_reg input has no effect in extended mode.
- R7: When sw_enable is 0, logical addressing never matches. Physical addressing and the shorthands behave as when enabled.
- R8: The shorthand selects the mode: 0 uses the destination field; 1 matches only when is_sender = 1; 2 always matches; 3 matches only when is_sender = 0.
- R9: match_q equals the value match had at the previous rising clock edge. A synchronous active-high reset clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered copy |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1 = extended addressing, 0 = legacy |
| sw_enable | input | 1 | Controller software-enable state |
| id_reg | input | 32 | Own ID register |
| ldr_reg | input | 32 | Logical destination register |
| dfr_reg | input | 32 | Destination format register |
| dest | input | 32 | Message destination field |
| dest_logical | input | 1 | 1 = logical addressing, 0 = physical |
| shorthand | input | 2 | Destination shorthand code |
| is_sender | input | 1 | This controller sent the message |
| match | output | 1 | Combinational target decision |
| match_q | output | 1 | Registered copy of match |

## Verification
The block holds no internal state apart from the output flop, so a wrong decision shows up on match as soon as the inputs settle. Two kinds of fault are therefore visible directly: a wrong nibble compare or a bad one-hot derivation. A fault in the registered path shows on match_q one edge later, either as a lost or stale copy or as a nonzero value after reset. The stimulus targets the places where a slip would flip the bit: equal and unequal upper nibbles, single-bit masks that only just overlap or miss, all-ones destinations and inputs that should be ignored.

// File: rtl/dm_pkg.sv
package dm_pkg;

    localparam int DM_REG_W  = 32;
    localparam int DM_LEG_W  = 8;
    localparam int DM_MASK_W = 16;
    localparam int DM_FMT_W  = 4;

    localparam logic [DM_FMT_W-1:0] FMT_FLAT    = 4'hF;
    localparam logic [DM_FMT_W-1:0] FMT_CLUSTER = 4'h0;

    typedef enum logic [1:0] {
        SH_DEST     = 2'd0,
        SH_SELF     = 2'd1,
        SH_ALL_INCL = 2'd2,
        SH_ALL_EXCL = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic                ext_mode;
        logic                sw_en;
        logic [DM_REG_W-1:0] id_reg;
        logic [DM_REG_W-1:0] ldr_reg;
        logic [DM_REG_W-1:0] dfr_reg;
    } self_cfg_t;

    typedef struct packed {
        logic [DM_REG_W-1:0] dest;
        logic                logical;
        shorthand_e          shorthand;
        logic                from_self;
    } ipi_msg_t;

    // Extended-mode logical ID: upper half = ID >> 4, lower half = one-hot of ID[3:0]
    function automatic logic [DM_REG_W-1:0] ext_logical_id(input logic [DM_REG_W-1:0] id);
        logic [DM_MASK_W-1:0] onehot;
        logic [DM_REG_W-1:0]  shifted;
        onehot  = DM_MASK_W'(1) << id[3:0];
        shifted = id >> 4;
        return {shifted[DM_MASK_W-1:0], onehot};
    endfunction

endpackage

// File: rtl/dm_phys_match.sv
module dm_phys_match
    import dm_pkg::*;
#(
    parameter int REG_W = DM_REG_W,
    parameter int LEG_W = DM_LEG_W
) (
    input  logic             ext_mode,
    input  logic [REG_W-1:0] id_reg,
    input  logic [REG_W-1:0] dest,
    output logic             hit
);
    localparam int LEG_LSB = REG_W - LEG_W;

    logic [LEG_W-1:0] own_leg;
    logic [LEG_W-1:0] dest_leg;
    logic             leg_hit;
    logic             ext_hit;

    assign own_leg  = id_reg[REG_W-1:LEG_LSB];
    assign dest_leg = dest[LEG_W-1:0];

    always_comb begin
        leg_hit = (dest_leg == own_leg) || (&dest_leg);
        ext_hit = (dest == id_reg) || (&dest);
        hit     = ext_mode ? ext_hit : leg_hit;
    end
endmodule

// File: rtl/dm_logical_match.sv
module dm_logical_match
    import dm_pkg::*;
#(
    parameter int REG_W = DM_REG_W,
    parameter int LEG_W = DM_LEG_W,
    parameter int FMT_W = DM_FMT_W
) (
    input  logic             ext_mode,
    input  logic             sw_en,
    input  logic [REG_W-1:0] id_reg,
    input  logic [REG_W-1:0] ldr_reg,
    input  logic [REG_W-1:0] dfr_reg,
    input  logic [REG_W-1:0] dest,
    output logic             hit
);
    localparam int LEG_LSB = REG_W - LEG_W;
    localparam int NIB_W   = LEG_W / 2;

    logic [LEG_W-1:0] lid;
    logic [LEG_W-1:0] mda;
    logic [FMT_W-1:0] model;
    logic [REG_W-1:0] ext_lid;
    logic             flat_hit;
    logic             clus_hit;
    logic             leg_hit;
    logic             ext_hit;

    assign lid     = ldr_reg[REG_W-1:LEG_LSB];
    assign mda     = dest[LEG_W-1:0];
    assign model   = dfr_reg[REG_W-1 -: FMT_W];
    assign ext_lid = ext_logical_id(id_reg);

    always_comb begin
        flat_hit = |(lid & mda);
        clus_hit = (lid[LEG_W-1:NIB_W] == mda[LEG_W-1:NIB_W]) &&
                   (|(lid[NIB_W-1:0] & mda[NIB_W-1:0]));
        unique case (model)
            FMT_FLAT:    leg_hit = flat_hit;
            FMT_CLUSTER: leg_hit = clus_hit;
            default:     leg_hit = 1'b0;
        endcase
        ext_hit = |(ext_lid & dest);
        hit     = sw_en && (ext_mode ? ext_hit : leg_hit);
    end
endmodule

// File: rtl/dm_shorthand_sel.sv
module dm_shorthand_sel
    import dm_pkg::*;
(
    input  shorthand_e shorthand,
    input  logic       from_self,
    input  logic       dest_hit,
    output logic       match
);
    always_comb begin
        unique case (shorthand)
            SH_DEST:     match = dest_hit;
            SH_SELF:     match = from_self;
            SH_ALL_INCL: match = 1'b1;
            SH_ALL_EXCL: match = !from_self;
            default:     match = 1'b0;
        endcase
    end
endmodule

// File: rtl/dest_match_unit.sv
module dest_match_unit
    import dm_pkg::*;
#(
    parameter int REG_W = DM_REG_W,
    parameter int LEG_W = DM_LEG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_mode,
    input  logic             sw_enable,
    input  logic [REG_W-1:0] id_reg,
    input  logic [REG_W-1:0] ldr_reg,
    input  logic [REG_W-1:0] dfr_reg,
    input  logic [REG_W-1:0] dest,
    input  logic             dest_logical,
    input  logic [1:0]       shorthand,
    input  logic             is_sender,
    output logic             match,
    output logic             match_q
);
    self_cfg_t  cfg;
    ipi_msg_t   msg;
    logic       phys_hit;
    logic       log_hit;
    logic       dest_hit;

    assign cfg = '{ext_mode: ext_mode, sw_en: sw_enable, id_reg: id_reg,
                   ldr_reg: ldr_reg, dfr_reg: dfr_reg};
    assign msg = '{dest: dest, logical: dest_logical,
                   shorthand: shorthand_e'(shorthand), from_self: is_sender};

    dm_phys_match #(.REG_W(REG_W), .LEG_W(LEG_W)) i_phys (
        .ext_mode (cfg.ext_mode),
        .id_reg   (cfg.id_reg),
        .dest     (msg.dest),
        .hit      (phys_hit)
    );

    dm_logical_match #(.REG_W(REG_W), .LEG_W(LEG_W)) i_logical (
        .ext_mode (cfg.ext_mode),
        .sw_en    (cfg.sw_en),
        .id_reg   (cfg.id_reg),
        .ldr_reg  (cfg.ldr_reg),
        .dfr_reg  (cfg.dfr_reg),
        .dest     (msg.dest),
        .hit      (log_hit)
    );

    assign dest_hit = msg.logical ? log_hit : phys_hit;

    dm_shorthand_sel i_sh (
        .shorthand (msg.shorthand),
        .from_self (msg.from_self),
        .dest_hit  (dest_hit),
        .match     (match)
    );

    always_ff @(posedge clk) begin
        if (rst) match_q <= 1'b0;
        else     match_q <= match;
    end

    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (rst)
        (shorthand == 2'd1) |-> (match == is_sender));                                  // R8
    AST_ALL_EXCL: assert property (@(posedge clk) disable iff (rst)
        (shorthand == 2'd3) |-> (match != is_sender));                                  // R8
    AST_LEG_BCAST: assert property (@(posedge clk) disable iff (rst)
        (shorthand == 2'd0 && !dest_logical && !ext_mode && (&dest[LEG_W-1:0])) |-> match); // R2
    AST_DISABLED_NO_LOGICAL: assert property (@(posedge clk) disable iff (rst)
        (shorthand == 2'd0 && dest_logical && !sw_enable) |-> !match);                  // R7
    AST_EXT_BCAST: assert property (@(posedge clk) disable iff (rst)
        (shorthand == 2'd0 && !dest_logical && ext_mode && (&dest)) |-> match);         // R3
endmodule

// File: tb/test_dest_match_unit.sv
module test_dest_match_unit;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst;
    logic        ext_mode, sw_enable, dest_logical, is_sender;
    logic [31:0] id_reg, ldr_reg, dfr_reg, dest;
    logic [1:0]  shorthand;
    logic        match, match_q;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(HALF) clk = ~clk;

    dest_match_unit i_dest_match_unit (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .sw_enable(sw_enable),
        .id_reg(id_reg), .ldr_reg(ldr_reg), .dfr_reg(dfr_reg), .dest(dest),
        .dest_logical(dest_logical), .shorthand(shorthand), .is_sender(is_sender),
        .match(match), .match_q(match_q)
    );

    function automatic bit model(bit ext, bit en, logic [31:0] id, logic [31:0] ldr,
                                 logic [31:0] dfr, logic [31:0] d, bit lg, logic [1:0] sh,
                                 bit snd);
        bit hit;
        logic [31:0] xl;
        if (sh == 2'd1) return snd;
        if (sh == 2'd2) return 1'b1;
        if (sh == 2'd3) return !snd;
        if (!lg) begin
            if (ext) hit = (d == id) || (d == 32'hFFFF_FFFF);
            else     hit = (d[7:0] == id[31:24]) || (d[7:0] == 8'hFF);
        end else if (!en) begin
            hit = 1'b0;
        end else if (ext) begin
            xl = 32'h0;
            xl[31:16] = id[19:4];
            xl[id[3:0]] = 1'b1;
            hit = (xl & d) != 0;
        end else if (dfr[31:28] == 4'hF) begin
            hit = (ldr[31:24] & d[7:0]) != 0;
        end else if (dfr[31:28] == 4'h0) begin
            hit = (ldr[31:28] == d[7:4]) && ((ldr[27:24] & d[3:0]) != 0);
        end else begin
            hit = 1'b0;
        end
        return hit;
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic apply(bit ext, bit en, logic [31:0] id, logic [31:0] ldr, logic [31:0] dfr,
                         logic [31:0] d, bit lg, logic [1:0] sh, bit snd, string tag);
        bit e;
        @(negedge clk);
        ext_mode = ext; sw_enable = en; id_reg = id; ldr_reg = ldr; dfr_reg = dfr;
        dest = d; dest_logical = lg; shorthand = sh; is_sender = snd;
        e = model(ext, en, id, ldr, dfr, d, lg, sh, snd);
        #1;
        check(tag, match, e, "match");
        @(negedge clk);
        check("R9", match_q, e, "match_q");
    endtask

    initial begin
        #(HALF * 2 * 100000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit ext, en, lg, snd;
        logic [31:0] id, ldr, dfr, d;
        logic [1:0] sh;
        rst = 1'b1;
        ext_mode = 0; sw_enable = 1; id_reg = 0; ldr_reg = 0; dfr_reg = 32'hFFFF_FFFF;
        dest = 0; dest_logical = 0; shorthand = 2'd2; is_sender = 0;
        repeat (3) @(negedge clk);
        check("R9", match_q, 1'b0, "match_q after reset");
        rst = 1'b0;

        // R1 legacy physical
        apply(0, 1, 32'h0500_0000, 0, 32'hFFFF_FFFF, 32'hABCD_EF05, 0, 0, 0, "R1");
        apply(0, 1, 32'h0500_0000, 0, 32'hFFFF_FFFF, 32'h0000_0006, 0, 0, 0, "R1");
        // R2 legacy broadcast
        apply(0, 1, 32'h0500_0000, 0, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 0, 1, "R2");
        // R3 extended physical
        apply(1, 1, 32'h0000_0123, 0, 0, 32'h0000_0123, 0, 0, 0, "R3");
        apply(1, 1, 32'h0000_0123, 0, 0, 32'h0000_0023, 0, 0, 0, "R3");
        apply(1, 1, 32'h0000_0123, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, "R3");
        apply(1, 1, 32'h0000_0123, 0, 0, 32'h0000_00FF, 0, 0, 0, "R3");
        // R4 flat
        apply(0, 1, 0, 32'h1200_0000, 32'hFFFF_FFFF, 32'h0000_0002, 1, 0, 0, "R4");
        apply(0, 1, 0, 32'h1200_0000, 32'hFFFF_FFFF, 32'h0000_000C, 1, 0, 0, "R4");
        // R5 cluster
        apply(0, 1, 0, 32'h3100_0000, 32'h0123_4567, 32'h0000_0033, 1, 0, 0, "R5");
        apply(0, 1, 0, 32'h3100_0000, 32'h0000_0000, 32'h0000_0021, 1, 0, 0, "R5");
        apply(0, 1, 0, 32'h3100_0000, 32'h0FFF_FFFF, 32'h0000_0032, 1, 0, 0, "R5");
        apply(0, 1, 0, 32'h3100_0000, 32'h5FFF_FFFF, 32'h0000_0031, 1, 0, 0, "R5");
        // R6 extended logical, ldr_reg ignored
        apply(1, 1, 32'h0000_0025, 32'hFFFF_FFFF, 0, 32'h0000_0020, 1, 0, 0, "R6");
        apply(1, 1, 32'h0000_0025, 32'hFFFF_FFFF, 0, 32'h0000_0010, 1, 0, 0, "R6");
        apply(1, 1, 32'h0000_0025, 32'h0000_0000, 0, 32'h0002_0000, 1, 0, 0, "R6");
        // R7 software disabled
        apply(0, 0, 32'h0500_0000, 32'hFF00_0000, 32'hFFFF_FFFF, 32'h0000_00FF, 1, 0, 0, "R7");
        apply(0, 0, 32'h0500_0000, 32'hFF00_0000, 32'hFFFF_FFFF, 32'h0000_0005, 0, 0, 0, "R7");
        apply(0, 0, 32'h0500_0000, 32'hFF00_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1, 2, 0, "R7");
        // R8 shorthands
        apply(0, 1, 32'h0500_0000, 0, 32'hFFFF_FFFF, 32'h0000_0005, 0, 1, 1, "R8");
        apply(0, 1, 32'h0500_0000, 0, 32'hFFFF_FFFF, 32'h0000_0005, 0, 1, 0, "R8");
        apply(0, 1, 32'h0500_0000, 0, 32'hFFFF_FFFF, 32'h0000_0000, 0, 2, 1, "R8");
        apply(0, 1, 32'h0500_0000, 0, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 3, 1, "R8");
        apply(0, 1, 32'h0500_0000, 0, 32'hFFFF_FFFF, 32'h0000_0000, 0, 3, 0, "R8");

        // constrained random
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 600; i++) begin
            ext = $urandom_range(0, 1);
            en  = ($urandom_range(0, 7) != 0);
            lg  = $urandom_range(0, 1);
            snd = $urandom_range(0, 1);
            sh  = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            id  = ext ? 32'($urandom_range(0, 511)) : {8'($urandom_range(0, 15)), 24'h0};
            ldr = {8'($urandom_range(0, 255)), 24'($urandom)};
            case ($urandom_range(0, 2))
                0:       dfr = {4'hF, 28'($urandom)};
                1:       dfr = {4'h0, 28'($urandom)};
                default: dfr = $urandom;
            endcase
            case ($urandom_range(0, 3))
                0:       d = ext ? id : {24'($urandom), id[31:24]};
                1:       d = ext ? 32'hFFFF_FFFF : {24'($urandom), 8'hFF};
                2:       d = 32'($urandom_range(0, 255));
                default: d = $urandom;
            endcase
            if (sh != 2'd0)      apply(ext, en, id, ldr, dfr, d, lg, sh, snd, "R8");
            else if (lg && !en)  apply(ext, en, id, ldr, dfr, d, lg, sh, snd, "R7");
            else if (lg && ext)  apply(ext, en, id, ldr, dfr, d, lg, sh, snd, "R6");
            else if (lg)         apply(ext, en, id, ldr, dfr, d, lg, sh, snd,
                                       (dfr[31:28] == 4'hF) ? "R4" : "R5");
            else if (ext)        apply(ext, en, id, ldr, dfr, d, lg, sh, snd, "R3");
            else                 apply(ext, en, id, ldr, dfr, d, lg, sh, snd, "R1");
        end

        // R9 reset clears the registered copy
        @(negedge clk);
        shorthand = 2'd2;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9", match_q, 1'b0, "match_q after mid-run reset");
        rst = 1'b0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule